// File: doc/BRIEF.md
# Dual-Port Mailbox Access Controller

This block sits on both sides of a bidirectional FIFO pair and turns each port's select, direction, enable and mailbox-select inputs into access strobes on every rising edge of that port's clock. The decode picks one of five outcomes per port: FIFO write, mailbox write, FIFO read, mailbox read or idle. It also raises an output-enable for the port's external tri-state driver. The FIFO memories sit outside the block and receive the FIFO write and read strobes. The block registers the read data the FIFO returns onto the port's output bus.

Two 36-bit mailbox registers carry single words across the ports, beside the FIFOs. Mailbox 1 is written from port A and read from port B. Mailbox 2 is written from port B and read from port A. Each mailbox has an active-low flag in the reader's clock domain that shows a word is waiting. Toggle synchronizers carry the write and read events between the clock domains in both directions. This lets the writer's side see when the word has been taken, and it refuses a second write until then.

Top module: `mailbox_port_ctrl`

## Requirements
- R1: Port A output enable `oeA` is 1 exactly when `csAN` is 0 and `wrA` is 0; otherwise it is 0.
- R2: Port B output enable `oeB` is 1 exactly when `csBN` is 0 and `rdB` is 1; otherwise it is 0.
- R3: Port A decode with `csAN`=0, `enA`=1, `mbA`=0: `wrA`=1 raises `fifo1WrA` and `wrA`=0 raises `fifo2RdA`. With `mbA`=1 the access goes to a mailbox and neither FIFO strobe rises.
- R4: Port B decode with `csBN`=0, `enB`=1, `mbB`=0: `rdB`=0 raises `fifo2WrB` and `rdB`=1 raises `fifo1RdB`. With `mbB`=1 neither FIFO strobe rises.
- R5: With the port enable at 0, no FIFO strobe rises, no mailbox is written or read, and no flag changes, whatever the other inputs are.
- R6: A mailbox write stores the input bus word. The reader-side flag (`mbf1N` for mailbox 1 on clkB, `mbf2N` for mailbox 2 on clkA) then goes to 0 within 5 reader clock cycles.
- R7: A mailbox write issued while the previous word has not been read yet, including until the read event has crossed back to the writer, is ignored. The stored word is unchanged.
- R8: A mailbox read while the flag is 0 puts the stored word on the port's `dataOut` at the edge and returns the flag to 1 at the same edge.
- R9: A FIFO read puts the port's `fifoData` input, sampled at that edge, on the port's `dataOut`.
- R10: With no read on a port, its `dataOut` holds its previous value.
- R11: Reset (`rstN`=0) clears both mailbox words and both `dataOut` registers to 0 and sets both flags to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Master reset, active low, asynchronous assert |
| csAN | input | 1 | Port A select, active low |
| wrA | input | 1 | Port A direction, 1 = write, 0 = read |
| enA | input | 1 | Port A access enable |
| mbA | input | 1 | Port A mailbox select |
| dataInA | input | 36 | Port A write data |
| fifoDataA | input | 36 | Read data from FIFO2 for port A |
| dataOutA | output | 36 | Port A registered read data |
| oeA | output | 1 | Port A tri-state output enable |
| fifo1WrA | output | 1 | FIFO1 write strobe |
| fifo2RdA | output | 1 | FIFO2 read strobe |
| mbf2N | output | 1 | Mailbox 2 waiting, active low, clkA domain |
| csBN | input | 1 | Port B select, active low |
| rdB | input | 1 | Port B direction, 1 = read, 0 = write |
| enB | input | 1 | Port B access enable |
| mbB | input | 1 | Port B mailbox select |
| dataInB | input | 36 | Port B write data |
| fifoDataB | input | 36 | Read data from FIFO1 for port B |
| dataOutB | output | 36 | Port B registered read data |
| oeB | output | 1 | Port B tri-state output enable |
| fifo2WrB | output | 1 | FIFO2 write strobe |
| fifo1RdB | output | 1 | FIFO1 read strobe |
| mbf1N | output | 1 | Mailbox 1 waiting, active low, clkB domain |

## Verification
Some properties are checked on every cycle. At most one strobe per port is active, and none with the enable low. An output enable accompanies every read. A mailbox word stays still while its writer is locked out. A flag falls only while the writer's lock is held, and it rises on a mailbox read. A read presents the mailbox word or the FIFO data. Other behaviour only the bench scenarios can show: the flag latency across the clock domains, a write refused before its acknowledge has returned, and a fresh write accepted after that. The same holds for the reset contents seen at the ports.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic fifoWr;
    logic fifoRd;
    logic mailWr;
    logic mailRd;
  } portStrobe_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter bit WRITE_LEVEL = 1'b1
) (
  input  logic        csN,
  input  logic        dirSel,
  input  logic        en,
  input  logic        mbSel,
  output portStrobe_t strb,
  output logic        oe
);
  logic selWrite;
  logic selRead;

  assign selWrite = !csN && (dirSel == WRITE_LEVEL);
  assign selRead  = !csN && (dirSel != WRITE_LEVEL);
  assign oe       = selRead;

  always_comb begin
    strb        = '0;
    strb.fifoWr = selWrite && en && !mbSel;
    strb.mailWr = selWrite && en &&  mbSel;
    strb.fifoRd = selRead  && en && !mbSel;
    strb.mailRd = selRead  && en &&  mbSel;
  end

  always_comb begin
    if (!$isunknown({csN, dirSel, en, mbSel})) begin
      p_one_access_r3: assert ($onehot0(strb));
      p_idle_disabled_r5: assert (en || (strb == '0));
      p_read_drives_r1: assert (!(strb.fifoRd || strb.mailRd) || oe);
    end
  end
endmodule

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic togIn,
  output logic pulse
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[DEPTH-2:0], togIn};
  end

  assign pulse = chain[DEPTH-1] ^ chain[DEPTH-2];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdReq,
  output logic [DATA_W-1:0] mailData,
  output logic              flagN
);
  logic wrBusy;
  logic wrTog;
  logic rdTog;
  logic notePulse;
  logic ackPulse;
  logic accept;

  assign accept = wrReq && !wrBusy;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      mailData <= '0;
      wrBusy   <= 1'b0;
      wrTog    <= 1'b0;
    end else if (accept) begin
      mailData <= wrData;
      wrBusy   <= 1'b1;
      wrTog    <= ~wrTog;
    end else if (ackPulse) begin
      wrBusy   <= 1'b0;
    end
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_noteSync (
    .clk(rdClk), .rstN(rstN), .togIn(wrTog), .pulse(notePulse)
  );

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      flagN <= 1'b1;
      rdTog <= 1'b0;
    end else if (rdReq && !flagN) begin
      flagN <= 1'b1;
      rdTog <= ~rdTog;
    end else if (notePulse) begin
      flagN <= 1'b0;
    end
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(wrClk), .rstN(rstN), .togIn(rdTog), .pulse(ackPulse)
  );

  p_locked_word_r7: assert property (@(posedge wrClk) disable iff (!rstN)
    wrBusy |=> $stable(mailData));
  p_flag_needs_lock_r6: assert property (@(posedge rdClk) disable iff (!rstN)
    $fell(flagN) |-> wrBusy);
  p_read_sets_flag_r8: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdReq && !flagN) |=> flagN);
endmodule

// File: rtl/mbx_port_out.sv
module mbx_port_out
  import mbx_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strb,
  input  logic              mailFull,
  input  logic [DATA_W-1:0] mailData,
  input  logic [DATA_W-1:0] fifoData,
  output logic [DATA_W-1:0] dataOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataOut <= '0;
    else if (strb.mailRd) dataOut <= mailData;
    else if (strb.fifoRd) dataOut <= fifoData;
  end

  p_mail_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mailRd && mailFull) |=> (dataOut == $past(mailData)));
  p_fifo_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.fifoRd |=> (dataOut == $past(fifoData)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.fifoRd || strb.mailRd) |=> $stable(dataOut));
endmodule

// File: rtl/mailbox_port_ctrl.sv
module mailbox_port_ctrl
  import mbx_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              csAN,
  input  logic              wrA,
  input  logic              enA,
  input  logic              mbA,
  input  logic [DATA_W-1:0] dataInA,
  input  logic [DATA_W-1:0] fifoDataA,
  output logic [DATA_W-1:0] dataOutA,
  output logic              oeA,
  output logic              fifo1WrA,
  output logic              fifo2RdA,
  output logic              mbf2N,
  input  logic              csBN,
  input  logic              rdB,
  input  logic              enB,
  input  logic              mbB,
  input  logic [DATA_W-1:0] dataInB,
  input  logic [DATA_W-1:0] fifoDataB,
  output logic [DATA_W-1:0] dataOutB,
  output logic              oeB,
  output logic              fifo2WrB,
  output logic              fifo1RdB,
  output logic              mbf1N
);
  portStrobe_t strbA;
  portStrobe_t strbB;
  logic [DATA_W-1:0] mail1Data;
  logic [DATA_W-1:0] mail2Data;

  mbx_decode #(.WRITE_LEVEL(1'b1)) u_decA (
    .csN(csAN), .dirSel(wrA), .en(enA), .mbSel(mbA), .strb(strbA), .oe(oeA)
  );
  mbx_decode #(.WRITE_LEVEL(1'b0)) u_decB (
    .csN(csBN), .dirSel(rdB), .en(enB), .mbSel(mbB), .strb(strbB), .oe(oeB)
  );

  assign fifo1WrA = strbA.fifoWr;
  assign fifo2RdA = strbA.fifoRd;
  assign fifo2WrB = strbB.fifoWr;
  assign fifo1RdB = strbB.fifoRd;

  mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
    .wrClk(clkA), .rdClk(clkB), .rstN(rstN),
    .wrReq(strbA.mailWr), .wrData(dataInA), .rdReq(strbB.mailRd),
    .mailData(mail1Data), .flagN(mbf1N)
  );
  mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
    .wrClk(clkB), .rdClk(clkA), .rstN(rstN),
    .wrReq(strbB.mailWr), .wrData(dataInB), .rdReq(strbA.mailRd),
    .mailData(mail2Data), .flagN(mbf2N)
  );

  mbx_port_out #(.DATA_W(DATA_W)) u_outA (
    .clk(clkA), .rstN(rstN), .strb(strbA), .mailFull(!mbf2N),
    .mailData(mail2Data), .fifoData(fifoDataA), .dataOut(dataOutA)
  );
  mbx_port_out #(.DATA_W(DATA_W)) u_outB (
    .clk(clkB), .rstN(rstN), .strb(strbB), .mailFull(!mbf1N),
    .mailData(mail1Data), .fifoData(fifoDataB), .dataOut(dataOutB)
  );
endmodule

// File: tb/mailbox_port_ctrl_tb.sv
module mailbox_port_ctrl_tb;
  localparam int W = 36;
  logic clkA = 0, clkB = 0, rstN = 0;
  logic csAN, wrA, enA, mbA, csBN, rdB, enB, mbB;
  logic [W-1:0] dataInA, fifoDataA, dataInB, fifoDataB, dataOutA, dataOutB;
  logic oeA, oeB, fifo1WrA, fifo2RdA, fifo2WrB, fifo1RdB, mbf1N, mbf2N;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clkA = ~clkA;
  always #3 clkB = ~clkB;

  mailbox_port_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {write strobe, read strobe, oe} for a port
  function automatic logic [2:0] expPort(input logic csN, input logic isWr,
                                         input logic en, input logic mb);
    logic wrSel = !csN && isWr;
    logic rdSel = !csN && !isWr;
    return {wrSel && en && !mb, rdSel && en && !mb, rdSel};
  endfunction

  task automatic tickA(); @(posedge clkA); @(negedge clkA); endtask
  task automatic tickB(); @(posedge clkB); @(negedge clkB); endtask

  task automatic idleA(); csAN = 1; wrA = 0; enA = 0; mbA = 0; endtask
  task automatic idleB(); csBN = 1; rdB = 0; enB = 0; mbB = 0; endtask

  task automatic waitFlag1(output int n);
    n = 99;
    for (int i = 1; i <= 8; i++) begin tickB(); if (!mbf1N) begin n = i; break; end end
  endtask
  task automatic waitFlag2(output int n);
    n = 99;
    for (int i = 1; i <= 8; i++) begin tickA(); if (!mbf2N) begin n = i; break; end end
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] expOut;
    logic [2:0] e;
    int n;
    void'($urandom(32'h5eed));
    idleA(); idleB();
    dataInA = '0; dataInB = '0; fifoDataA = '0; fifoDataB = '0;
    #15 rstN = 1;
    @(negedge clkA);
    // R11 reset state
    chk("R11 mbf1N", mbf1N, 1); chk("R11 mbf2N", mbf2N, 1);
    chk("R11 dataOutA", dataOutA, 0); chk("R11 dataOutB", dataOutB, 0);

    // random port A decode, FIFO only (R1 R3 R5 R9 R10)
    expOut = '0;
    for (int i = 0; i < 300; i++) begin
      csAN = 1'($urandom); wrA = 1'($urandom); enA = 1'($urandom); mbA = 0;
      fifoDataA = {4'($urandom), 32'($urandom)};
      #1;
      e = expPort(csAN, wrA, enA, mbA);
      chk("R3 fifo1WrA", fifo1WrA, e[2]); chk("R3 fifo2RdA", fifo2RdA, e[1]);
      chk("R1 oeA", oeA, e[0]);
      if (!enA) chk("R5 no strobe A", {fifo1WrA, fifo2RdA}, 0);
      if (e[1]) expOut = fifoDataA;
      tickA();
      chk(e[1] ? "R9 dataOutA" : "R10 dataOutA hold", dataOutA, expOut);
    end
    idleA();
    // random port B decode (R2 R4 R9 R10)
    expOut = dataOutB;
    for (int i = 0; i < 300; i++) begin
      csBN = 1'($urandom); rdB = 1'($urandom); enB = 1'($urandom); mbB = 0;
      fifoDataB = {4'($urandom), 32'($urandom)};
      #1;
      e = expPort(csBN, !rdB, enB, mbB);
      chk("R4 fifo2WrB", fifo2WrB, e[2]); chk("R4 fifo1RdB", fifo1RdB, e[1]);
      chk("R2 oeB", oeB, e[0]);
      if (e[1]) expOut = fifoDataB;
      tickB();
      chk(e[1] ? "R9 dataOutB" : "R10 dataOutB hold", dataOutB, expOut);
    end
    idleB();

    // R5 disabled mailbox write changes nothing
    @(negedge clkA); csAN = 0; wrA = 1; enA = 0; mbA = 1; dataInA = 36'h123456789;
    tickA(); idleA();
    for (int i = 0; i < 6; i++) tickB();
    chk("R5 mbf1N after disabled write", mbf1N, 1);

    // R3 R6 mailbox 1 write from A
    @(negedge clkA); csAN = 0; wrA = 1; enA = 1; mbA = 1; dataInA = 36'hA5A5A5A51;
    #1 chk("R3 mailbox write no fifo strobe", fifo1WrA, 0);
    tickA(); idleA();
    waitFlag1(n);
    chk("R6 mbf1N low within 5", (n <= 5), 1);
    // R7 second write ignored
    @(negedge clkA); csAN = 0; wrA = 1; enA = 1; mbA = 1; dataInA = 36'h0DEADBEEF;
    tickA(); idleA();
    // R5 disabled mailbox read
    @(negedge clkB); csBN = 0; rdB = 1; enB = 0; mbB = 1;
    tickB();
    chk("R5 mbf1N after disabled read", mbf1N, 0);
    // R8 read mailbox 1
    enB = 1; #1 chk("R4 mailbox read no fifo strobe", fifo1RdB, 0);
    tickB(); idleB();
    chk("R7/R8 dataOutB", dataOutB, 36'hA5A5A5A51);
    chk("R8 mbf1N high", mbf1N, 1);
    for (int i = 0; i < 8; i++) tickA();
    // new write accepted after ack (R6)
    @(negedge clkA); csAN = 0; wrA = 1; enA = 1; mbA = 1; dataInA = 36'h777000111;
    tickA(); idleA();
    waitFlag1(n);
    chk("R6 mbf1N second word", (n <= 5), 1);
    @(negedge clkB); csBN = 0; rdB = 1; enB = 1; mbB = 1;
    tickB(); idleB();
    chk("R8 dataOutB second word", dataOutB, 36'h777000111);

    // mailbox 2 from B to A
    @(negedge clkB); csBN = 0; rdB = 0; enB = 1; mbB = 1; dataInB = 36'h9C3C3C3C3;
    #1 chk("R4 mailbox write no fifo2WrB", fifo2WrB, 0);
    tickB(); idleB();
    waitFlag2(n);
    chk("R6 mbf2N low within 5", (n <= 5), 1);
    @(negedge clkB); csBN = 0; rdB = 0; enB = 1; mbB = 1; dataInB = 36'h111111111;
    tickB(); idleB();
    @(negedge clkA); csAN = 0; wrA = 0; enA = 1; mbA = 1;
    #1 chk("R1 oeA on mailbox read", oeA, 1);
    tickA(); idleA();
    chk("R7/R8 dataOutA", dataOutA, 36'h9C3C3C3C3);
    chk("R8 mbf2N high", mbf2N, 1);

    // R11 reset with a word waiting
    @(negedge clkA); csAN = 0; wrA = 1; enA = 1; mbA = 1; dataInA = 36'hFFFFFFFFF;
    tickA(); idleA();
    waitFlag1(n);
    rstN = 0; #10;
    chk("R11 mbf1N in reset", mbf1N, 1);
    chk("R11 dataOutA in reset", dataOutA, 0); chk("R11 dataOutB in reset", dataOutB, 0);
    rstN = 1;
    @(negedge clkB); csBN = 0; rdB = 1; enB = 1; mbB = 1;
    tickB(); idleB();
    chk("R11 mailbox 1 cleared", dataOutB, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule